// File: doc/BRIEF.md
# I3C Target Register-Read Controller with Packet Error Checking

This block is the byte-level transaction engine of an I3C Basic target that answers register reads. A bit-level front end, outside this block, turns bus activity into single-cycle events: start, repeated start, stop, a received header byte (7-bit address plus read/write bit), each written byte with its parity-error flag, and a request for the next read byte. The block answers each header with ACK or NACK, supplies read bytes and the T-bit for each one, and fetches data through a combinational register-file port.

When packet error checking is enabled, the write phase carries three bytes: register pointer, a length command and a CRC-8 check byte. The read phase returns the requested one or two bytes followed by a CRC-8 byte of its own. A parity error or a check-byte mismatch is latched in a sticky two-bit status. While either bit is set, the target refuses every header addressed to it until the host clears the bit through a dedicated write-one-to-clear input.

Top module: `i3c_rdpec_target`

## Requirements
- R1: A header whose upper seven bits equal TGT_ADDR produces, one cycle later, a single-cycle `resp_valid` with `resp_ack` = 1 for a write header when no error is latched. A header for another address produces no response.
- R2: After an acknowledged write header, the first written byte sets the register pointer. With `pec_en` = 1, the next byte is the length command and the byte after it is the check byte. With `pec_en` = 0, the write is complete after the pointer byte.
- R3: The length command value 0x00 selects a one-byte read and 0x01 a two-byte read. Any other value causes the following read header to be NACKed and sets no status bit.
- R4: With PEC enabled, a valid read returns the data at pointer, pointer+1, ... with T-bit 1 on each, then one check byte with T-bit 0. Read requests after that byte produce no `rd_valid`.
- R5: The read check byte is the CRC-8 (polynomial 0x07, initial value 0x00, most significant bit first) over the read header byte followed by the returned data bytes.
- R6: The write check byte is compared with the CRC-8 over the write header byte, the pointer byte and the command byte. On a mismatch, `err_status[1]` is set and the read header is NACKed.
- R7: A parity error flagged on any byte of the write phase sets `err_status[0]`, and the read header is NACKed.
- R8: While either status bit is set, every header matching TGT_ADDR, read or write, including one after a repeated start, is answered with NACK.
- R9: Status bits survive stop and start conditions. A bit is cleared only by a pulse on the matching bit of `err_clr`, and clearing one bit leaves the other unchanged.
- R10: A two-byte read starting at pointer 255 takes its second byte from address 0.
- R11: With `pec_en` = 0, a read returns DEF_RD_LEN data bytes, the last one with T-bit 0, and no check byte.
- R12: After reset, `err_status` is 0 and no response or read byte is issued.
- R13: A read header that follows no completed write phase in the same transaction is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pec_en | input | 1 | Packet error checking enabled (static during transfers) |
| ev_start | input | 1 | Start condition seen |
| ev_rstart | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_addr | input | 1 | Header byte received |
| hdr_byte | input | 8 | Header: address in [7:1], read = 1 in [0] |
| ev_wbyte | input | 1 | Written byte received |
| wr_byte | input | 8 | Written byte value |
| wr_par_err | input | 1 | Parity error on this written byte |
| ev_rreq | input | 1 | Front end requests next read byte |
| err_clr | input | 2 | Write-one-to-clear: [0] parity, [1] check mismatch |
| rf_addr | output | 8 | Register-file read address |
| rf_rdata | input | 8 | Register-file data for rf_addr |
| resp_valid | output | 1 | Header response valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| rd_tbit | output | 1 | T-bit for this byte (0 = last) |
| err_status | output | 2 | Sticky status: [0] parity, [1] check mismatch |

## Verification
The hardest state to reach is a latched check mismatch. The host side must deliberately send a wrong check byte, so the bench computes the correct CRC itself and flips one bit before sending it. The bench then walks the target through repeated starts, a stop and a new start, and a partial clear, to show that the refusal persists until the right status bit is cleared. The pointer-255 wrap is reached by sweeping all 256 pointers with both length commands and with checking on and off.

// File: rtl/i3c_rdpec_pkg.sv
package i3c_rdpec_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WREG,
        PH_WCMD,
        PH_WPEC,
        PH_WDONE,
        PH_READ,
        PH_REND,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] LEN_CMD_ONE = 8'h00;
    localparam logic [7:0] LEN_CMD_TWO = 8'h01;

    typedef struct packed {
        phase_e     ph;
        logic [7:0] ptr;
        logic [7:0] cmd;
        logic       wr_ok;
        logic [1:0] cnt;
        logic [1:0] len;
        logic       resp_v;
        logic       resp_ack;
        logic       rd_v;
        logic [7:0] rd_data;
        logic       rd_t;
    } ctl_t;

    // One byte through a CRC-8 register, most significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pec_crc8.sv
module pec_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic       step,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import i3c_rdpec_pkg::*;

    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (seed) begin
            crc_d = crc8_step(8'h00, din, POLY);
        end else if (step) begin
            crc_d = crc8_step(crc_q, din, POLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= 8'h00;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/err_sticky.sv
module err_sticky #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] flag_d, flag_q;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_comb begin
            flag_d[g] = flag_q[g];
            if (clr[g]) flag_d[g] = 1'b0;
            if (set[g]) flag_d[g] = 1'b1;
        end

        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr[g]) |=> flag_q[g]); // R9
        AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !set[g]) |=> !flag_q[g]); // R9
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;

endmodule

// File: rtl/i3c_rdpec_target.sv
module i3c_rdpec_target #(
    parameter logic [6:0] TGT_ADDR   = 7'h2A,
    parameter int         DEF_RD_LEN = 2,
    parameter logic [7:0] PEC_POLY   = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pec_en,
    input  logic       ev_start,
    input  logic       ev_rstart,
    input  logic       ev_stop,
    input  logic       ev_addr,
    input  logic [7:0] hdr_byte,
    input  logic       ev_wbyte,
    input  logic [7:0] wr_byte,
    input  logic       wr_par_err,
    input  logic       ev_rreq,
    input  logic [1:0] err_clr,
    output logic [7:0] rf_addr,
    input  logic [7:0] rf_rdata,
    output logic       resp_valid,
    output logic       resp_ack,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_tbit,
    output logic [1:0] err_status
);
    import i3c_rdpec_pkg::*;

    localparam int         NERR      = 2;
    localparam int         ERR_PAR   = 0;
    localparam int         ERR_PEC   = 1;
    localparam logic [1:0] NOPEC_LEN = 2'(DEF_RD_LEN);

    ctl_t s_d, s_q;

    logic            w_seed, w_step, r_seed, r_step;
    logic [7:0]      w_din, r_din, w_crc, r_crc;
    logic [NERR-1:0] err_set, err_q;
    logic            hit, err_any, cmd_ok;
    logic            last_data;

    assign hit     = (hdr_byte[7:1] == TGT_ADDR);
    assign err_any = |err_q;
    assign cmd_ok  = (s_q.cmd == LEN_CMD_ONE) || (s_q.cmd == LEN_CMD_TWO);
    assign rf_addr = s_q.ptr + {6'd0, s_q.cnt};

    always_comb begin
        s_d       = s_q;
        s_d.resp_v = 1'b0;
        s_d.rd_v   = 1'b0;
        w_seed    = 1'b0;
        w_step    = 1'b0;
        r_seed    = 1'b0;
        r_step    = 1'b0;
        w_din     = ev_addr ? hdr_byte : wr_byte;
        r_din     = ev_addr ? hdr_byte : rf_rdata;
        err_set   = '0;
        last_data = 1'b0;

        if (ev_stop || ev_start) begin
            s_d.ph    = PH_IDLE;
            s_d.wr_ok = 1'b0;
        end else if (ev_rstart) begin
            s_d.ph = PH_IDLE;
        end else if (ev_addr) begin
            if (!hit) begin
                s_d.ph = PH_SKIP;
            end else begin
                s_d.resp_v = 1'b1;
                if (err_any) begin
                    s_d.resp_ack = 1'b0;
                    s_d.ph       = PH_SKIP;
                end else if (!hdr_byte[0]) begin
                    s_d.resp_ack = 1'b1;
                    s_d.ph       = PH_WREG;
                    s_d.wr_ok    = 1'b0;
                    w_seed       = 1'b1;
                end else if (s_q.wr_ok && (!pec_en || cmd_ok)) begin
                    s_d.resp_ack = 1'b1;
                    s_d.ph       = PH_READ;
                    s_d.cnt      = 2'd0;
                    s_d.len      = pec_en ? ((s_q.cmd == LEN_CMD_TWO) ? 2'd2 : 2'd1)
                                          : NOPEC_LEN;
                    r_seed       = 1'b1;
                end else begin
                    s_d.resp_ack = 1'b0;
                    s_d.ph       = PH_SKIP;
                end
            end
        end else if (ev_wbyte) begin
            if ((s_q.ph == PH_WREG) || (s_q.ph == PH_WCMD) || (s_q.ph == PH_WPEC)) begin
                err_set[ERR_PAR] = wr_par_err;
            end
            case (s_q.ph)
                PH_WREG: begin
                    s_d.ptr = wr_byte;
                    w_step  = 1'b1;
                    if (pec_en) begin
                        s_d.ph = PH_WCMD;
                    end else begin
                        s_d.ph    = PH_WDONE;
                        s_d.wr_ok = 1'b1;
                    end
                end
                PH_WCMD: begin
                    s_d.cmd = wr_byte;
                    w_step  = 1'b1;
                    s_d.ph  = PH_WPEC;
                end
                PH_WPEC: begin
                    err_set[ERR_PEC] = (wr_byte != w_crc);
                    s_d.ph           = PH_WDONE;
                    s_d.wr_ok        = 1'b1;
                end
                default: ;
            endcase
        end else if (ev_rreq && (s_q.ph == PH_READ)) begin
            s_d.rd_v = 1'b1;
            if (s_q.cnt < s_q.len) begin
                last_data   = ((s_q.cnt + 2'd1) == s_q.len);
                s_d.rd_data = rf_rdata;
                s_d.rd_t    = pec_en ? 1'b1 : !last_data;
                s_d.cnt     = s_q.cnt + 2'd1;
                r_step      = 1'b1;
                if (!pec_en && last_data) s_d.ph = PH_REND;
            end else begin
                s_d.rd_data = r_crc;
                s_d.rd_t    = 1'b0;
                s_d.ph      = PH_REND;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, ptr: 8'h00, cmd: 8'h00, wr_ok: 1'b0, cnt: 2'd0,
                     len: 2'd0, resp_v: 1'b0, resp_ack: 1'b0, rd_v: 1'b0,
                     rd_data: 8'h00, rd_t: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    pec_crc8 #(.POLY(PEC_POLY)) u_wcrc (
        .clk  (clk),
        .rst_n(rst_n),
        .seed (w_seed),
        .step (w_step),
        .din  (w_din),
        .crc  (w_crc)
    );

    pec_crc8 #(.POLY(PEC_POLY)) u_rcrc (
        .clk  (clk),
        .rst_n(rst_n),
        .seed (r_seed),
        .step (r_step),
        .din  (r_din),
        .crc  (r_crc)
    );

    err_sticky #(.NFLAG(NERR)) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (err_set),
        .clr  (err_clr),
        .flags(err_q)
    );

    assign resp_valid = s_q.resp_v;
    assign resp_ack   = s_q.resp_ack;
    assign rd_valid   = s_q.rd_v;
    assign rd_data    = s_q.rd_data;
    assign rd_tbit    = s_q.rd_t;
    assign err_status = err_q;

    AST_RESP_FROM_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(ev_addr)); // R1
    AST_ERR_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr && hit && (|err_status) && !ev_stop && !ev_start && !ev_rstart)
        |=> (resp_valid && !resp_ack)); // R8
    AST_RD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ev_rreq)); // R4
    AST_NONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_tbit) |=> !rd_valid); // R4

endmodule

// File: tb/tb_i3c_rdpec_target.sv
module tb_i3c_rdpec_target;

    localparam logic [6:0] A = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pec_en = 1'b1;
    logic       ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_addr = 0;
    logic [7:0] hdr_byte = 8'h00;
    logic       ev_wbyte = 0;
    logic [7:0] wr_byte = 8'h00;
    logic       wr_par_err = 0;
    logic       ev_rreq = 0;
    logic [1:0] err_clr = 2'b00;
    logic [7:0] rf_addr, rf_rdata;
    logic       resp_valid, resp_ack, rd_valid, rd_tbit;
    logic [7:0] rd_data;
    logic [1:0] err_status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    always_comb rf_rdata = rf_addr * 8'd29 + 8'd3;

    i3c_rdpec_target #(.TGT_ADDR(A), .DEF_RD_LEN(2), .PEC_POLY(8'h07)) dut (
        .clk(clk), .rst_n(rst_n), .pec_en(pec_en),
        .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
        .ev_addr(ev_addr), .hdr_byte(hdr_byte), .ev_wbyte(ev_wbyte),
        .wr_byte(wr_byte), .wr_par_err(wr_par_err), .ev_rreq(ev_rreq),
        .err_clr(err_clr), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .resp_valid(resp_valid), .resp_ack(resp_ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_tbit(rd_tbit), .err_status(err_status)
    );

    function automatic logic [7:0] rfm(input logic [7:0] a);
        return 8'(a * 8'd29 + 8'd3);
    endfunction

    // Serial-register CRC, one bit at a time, polynomial x^8+x^2+x+1.
    function automatic logic [7:0] crc_b(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] c;
        logic fb;
        c = crc;
        for (int k = 7; k >= 0; k--) begin
            fb = c[7] ^ b[k];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic p_start;
        @(negedge clk) ev_start = 1'b1;
        @(negedge clk) ev_start = 1'b0;
    endtask

    task automatic p_rstart;
        @(negedge clk) ev_rstart = 1'b1;
        @(negedge clk) ev_rstart = 1'b0;
    endtask

    task automatic p_stop;
        @(negedge clk) ev_stop = 1'b1;
        @(negedge clk) ev_stop = 1'b0;
    endtask

    task automatic hdr(input logic [6:0] a, input logic rw, output logic v, output logic ack);
        @(negedge clk);
        hdr_byte = {a, rw};
        ev_addr  = 1'b1;
        @(negedge clk);
        ev_addr = 1'b0;
        v   = resp_valid;
        ack = resp_ack;
    endtask

    task automatic wb(input logic [7:0] b, input logic par);
        @(negedge clk);
        wr_byte    = b;
        wr_par_err = par;
        ev_wbyte   = 1'b1;
        @(negedge clk);
        ev_wbyte   = 1'b0;
        wr_par_err = 1'b0;
    endtask

    task automatic rq(output logic v, output logic [7:0] d, output logic t);
        @(negedge clk) ev_rreq = 1'b1;
        @(negedge clk);
        ev_rreq = 1'b0;
        v = rd_valid;
        d = rd_data;
        t = rd_tbit;
    endtask

    task automatic pclr(input logic [1:0] m);
        @(negedge clk) err_clr = m;
        @(negedge clk) err_clr = 2'b00;
    endtask

    // Start, write header, pointer, and with PEC the command and check byte.
    task automatic wr_phase(input logic [7:0] r, input logic [7:0] c,
                            input logic bad, input logic par);
        logic v, ack;
        logic [7:0] crc;
        p_start();
        hdr(A, 1'b0, v, ack);
        check("R1 write header ACK", {v, ack}, 2'b11);
        wb(r, par);
        if (pec_en) begin
            crc = crc_b(crc_b(crc_b(8'h00, {A, 1'b0}), r), c);
            wb(c, 1'b0);
            wb(crc ^ (bad ? 8'h10 : 8'h00), 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic v, ack, t;
        logic [7:0] d, crc, ra;
        int n;

        repeat (3) @(negedge clk);
        check("R12 status after reset", err_status, 2'b00);
        check("R12 no response after reset", resp_valid, 1'b0);
        check("R12 no read byte after reset", rd_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: another address draws no response
        p_start();
        hdr(7'h11, 1'b0, v, ack);
        check("R1 foreign address silent", v, 1'b0);
        p_stop();

        // R13: read header with no write phase
        p_start();
        hdr(A, 1'b1, v, ack);
        check("R13 read without write NACK", {v, ack}, 2'b10);
        p_stop();

        // R4 R5 R10: every pointer, both lengths, PEC on
        pec_en = 1'b1;
        for (int r = 0; r < 256; r++) begin
            for (int c = 0; c < 2; c++) begin
                wr_phase(8'(r), 8'(c), 1'b0, 1'b0);
                p_rstart();
                hdr(A, 1'b1, v, ack);
                check("R4 read header ACK", {v, ack}, 2'b11);
                crc = crc_b(8'h00, {A, 1'b1});
                n = c + 1;
                for (int i = 0; i < n; i++) begin
                    ra = 8'(r + i);
                    rq(v, d, t);
                    if (r == 255 && i == 1)
                        check("R10 wrap to address 0", {v, d, t}, {1'b1, rfm(8'h00), 1'b1});
                    else
                        check("R4 data byte T=1", {v, d, t}, {1'b1, rfm(ra), 1'b1});
                    crc = crc_b(crc, rfm(ra));
                end
                rq(v, d, t);
                check("R5 read check byte", {v, d}, {1'b1, crc});
                check("R4 final T-bit 0", t, 1'b0);
                rq(v, d, t);
                check("R4 nothing after last", v, 1'b0);
                p_stop();
            end
        end

        // R3: invalid length commands
        for (int c = 2; c < 256; c += 3) begin
            wr_phase(8'h40, 8'(c), 1'b0, 1'b0);
            p_rstart();
            hdr(A, 1'b1, v, ack);
            check("R3 invalid command NACK", {v, ack}, 2'b10);
            check("R3 no status bit", err_status, 2'b00);
            p_stop();
        end

        // R11 R2: PEC off, pointer then read of two bytes
        pec_en = 1'b0;
        for (int r = 0; r < 256; r += 5) begin
            wr_phase(8'(r), 8'h00, 1'b0, 1'b0);
            p_rstart();
            hdr(A, 1'b1, v, ack);
            check("R2 pointer-only write allows read", {v, ack}, 2'b11);
            rq(v, d, t);
            check("R11 first byte", {v, d, t}, {1'b1, rfm(8'(r)), 1'b1});
            rq(v, d, t);
            check("R11 second byte last", {v, d, t}, {1'b1, rfm(8'(r + 1)), 1'b0});
            rq(v, d, t);
            check("R11 no check byte", v, 1'b0);
            p_stop();
        end
        wr_phase(8'hFF, 8'h00, 1'b0, 1'b0);
        p_rstart();
        hdr(A, 1'b1, v, ack);
        rq(v, d, t);
        rq(v, d, t);
        check("R10 wrap without PEC", {v, d, t}, {1'b1, rfm(8'h00), 1'b0});
        p_stop();
        pec_en = 1'b1;

        // R6 R8 R9: wrong check byte
        wr_phase(8'h22, 8'h01, 1'b1, 1'b0);
        check("R6 mismatch sets bit 1", err_status, 2'b10);
        p_rstart();
        hdr(A, 1'b1, v, ack);
        check("R6 read NACK on mismatch", {v, ack}, 2'b10);
        p_rstart();
        hdr(A, 1'b0, v, ack);
        check("R8 write header NACK after repeated start", {v, ack}, 2'b10);
        p_stop();
        check("R9 stop keeps status", err_status, 2'b10);
        p_start();
        hdr(A, 1'b1, v, ack);
        check("R8 header NACK after new start", {v, ack}, 2'b10);
        p_stop();
        pclr(2'b01);
        check("R9 other bit cleared only", err_status, 2'b10);
        pclr(2'b10);
        check("R9 clear bit 1", err_status, 2'b00);

        // R7: parity error on pointer byte
        wr_phase(8'h33, 8'h00, 1'b0, 1'b1);
        check("R7 parity sets bit 0", err_status, 2'b01);
        p_rstart();
        hdr(A, 1'b1, v, ack);
        check("R7 read NACK on parity", {v, ack}, 2'b10);
        p_stop();
        pclr(2'b01);
        check("R9 clear bit 0", err_status, 2'b00);

        // Recovery after clear
        wr_phase(8'h33, 8'h00, 1'b0, 1'b0);
        p_rstart();
        hdr(A, 1'b1, v, ack);
        check("R8 ACK again after clear", {v, ack}, 2'b11);
        rq(v, d, t);
        check("R4 data after recovery", {v, d, t}, {1'b1, rfm(8'h33), 1'b1});
        p_stop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule